// File: doc/BRIEF.md
# Three-Register Stack Execution Unit

This block runs already-decoded instructions on a small evaluation stack of three registers: A on top, B below it and C at the bottom. Each instruction arrives as a function code, a full-width operand with all prefixes already folded in, and the length in bytes of the encoded instruction. The block also holds the instruction pointer, the workspace pointer, a sticky error flag, a running/halted status and a counter that adds up the clock-cycle cost of every retired instruction.

Instructions enter over a valid/ready handshake. An instruction is consumed on a rising edge where `ins_valid` and `ins_ready` are both high. `ins_ready` is high while the unit runs and low from the moment it halts until the next reset. While `ins_ready` is low the producer must hold its instruction. Local loads and stores, and the pointer save made by the stop instruction, go through a single-cycle word-memory port. Its read data must be valid combinationally in the same cycle as the address, and a write takes effect at the same edge that retires the instruction. The stack drops its bottom value when a push fills it, with no overflow detection. The error flag has no reset value; software must set or clear it before it is relied on.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset the instruction pointer equals IPTR_RST, the workspace pointer equals WPTR_RST, the cycle counter is 0, `halted` is 0 and `ins_ready` is 1.
- R2: A push (load constant, fn 0; load local, fn 3; test error, fn 12) writes the new value into A, moves the old A into B and the old B into C. Load constant pushes the operand.
- R3: Add (fn 7, B+A), subtract (fn 8, B−A) and greater-than (fn 9) are two-operand operations. The result goes into A, the old C goes into B, and C keeps its old value.
- R4: Add, subtract and add constant (fn 1, A+operand into A, no stack movement) wrap modulo 2^WORD_W. A signed overflow sets the error flag; otherwise the flag is unchanged.
- R5: Greater-than leaves 1 in A when signed B > signed A and 0 otherwise. Equals-constant (fn 2) replaces A with 1 when A equals the operand and with 0 otherwise.
- R6: Load local (fn 3) reads, and store local (fn 4) writes, the word at workspace pointer + operand × BYTES_PER_WORD. Store local writes A and then pops: A takes B, B takes C.
- R7: Every instruction that does not branch sets the instruction pointer to the old pointer + `ins_len`. The unconditional jump (fn 5) adds the operand to that value. The conditional jump (fn 6) does the same only when A is 0, leaving the stack unchanged; when A is not 0 it falls through and pops.
- R8: Reverse (fn 10) swaps A and B and leaves C unchanged.
- R9: Set error (fn 11) sets the flag. Test error (fn 12) pushes 1 when the flag was set and 0 when it was clear, then clears the flag.
- R10: Stop-on-error (fn 13) halts only when the error flag is set. Stop (fn 14) always halts, and writes the instruction pointer of the following instruction to the word at workspace pointer − BYTES_PER_WORD.
- R11: While halted, `ins_ready` is 0 and no register, pointer or counter changes.
- R12: The cycle counter grows by the cost of each retired instruction. The costs are: load constant 1, add constant 1, equals-constant 2, load local 2, store local 1, jump 3, conditional jump 4 when taken and 2 when not, add 1, subtract 1, greater-than 2, reverse 1, set error 1, test error 2, stop-on-error 2, stop 11. Unused codes cost 1 and only advance the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit accepts an instruction this cycle |
| ins_fn | input | 4 | Function code |
| ins_oprnd | input | WORD_W | Folded operand |
| ins_len | input | LEN_W | Encoded instruction length in bytes |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | WORD_W | Byte address, word aligned |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, same cycle |
| reg_a | output | WORD_W | Stack top |
| reg_b | output | WORD_W | Stack middle |
| reg_c | output | WORD_W | Stack bottom |
| iptr | output | WORD_W | Instruction pointer |
| wptr | output | WORD_W | Workspace pointer |
| err_flag | output | 1 | Sticky error flag |
| halted | output | 1 | Unit stopped |
| cyc_count | output | CLK_W | Accumulated cycle cost |

## Verification
Two functions meet at one edge. The first is an overflowing add that raises the error flag. The second is the stop-on-error decision made by the instruction issued directly behind it. The bench drives the two back to back with `ins_valid` held high throughout. It then checks that the unit halts at once, that `ins_ready` drops in the very next cycle, and that a further instruction held on the handshake changes nothing. Stop is handled the same way: its memory write and its halt fall on the same edge, and the bench checks both the saved pointer in memory and the frozen registers.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [3:0] {
    FN_LDC     = 4'd0,
    FN_ADC     = 4'd1,
    FN_EQC     = 4'd2,
    FN_LDL     = 4'd3,
    FN_STL     = 4'd4,
    FN_JMP     = 4'd5,
    FN_CJMP    = 4'd6,
    FN_ADD     = 4'd7,
    FN_SUB     = 4'd8,
    FN_GT      = 4'd9,
    FN_REV     = 4'd10,
    FN_SETERR  = 4'd11,
    FN_TESTERR = 4'd12,
    FN_STOPERR = 4'd13,
    FN_STOP    = 4'd14,
    FN_NOP     = 4'd15
  } stk_fn_e;

  localparam int COST_W = 4;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  stk_fn_e           fn,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] oprnd,
  output logic [WORD_W-1:0] res,
  output logic              ovf
);
  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] x, y, sum, dif;

  always_comb begin
    x = (fn == FN_ADC) ? a : b;
    y = (fn == FN_ADC) ? oprnd : a;
    sum = x + y;
    dif = b - a;
    res = '0;
    ovf = 1'b0;
    unique case (fn)
      FN_ADD, FN_ADC: begin
        res = sum;
        ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
      end
      FN_SUB: begin
        res = dif;
        ovf = (b[MSB] != a[MSB]) && (dif[MSB] != b[MSB]);
      end
      FN_GT:   res = {{(WORD_W-1){1'b0}}, ($signed(b) > $signed(a))};
      FN_EQC:  res = {{(WORD_W-1){1'b0}}, (a == oprnd)};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_branch.sv
module stk_branch
  import stk_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 4
) (
  input  stk_fn_e           fn,
  input  logic [WORD_W-1:0] iptr,
  input  logic [LEN_W-1:0]  len,
  input  logic [WORD_W-1:0] oprnd,
  input  logic              a_zero,
  output logic [WORD_W-1:0] seq_iptr,
  output logic [WORD_W-1:0] nxt_iptr,
  output logic              taken
);
  always_comb begin
    seq_iptr = iptr + WORD_W'(len);
    taken    = (fn == FN_JMP) || ((fn == FN_CJMP) && a_zero);
    nxt_iptr = taken ? (seq_iptr + oprnd) : seq_iptr;
  end
endmodule

// File: rtl/stk_cost.sv
module stk_cost
  import stk_pkg::*;
(
  input  stk_fn_e           fn,
  input  logic              taken,
  output logic [COST_W-1:0] cost
);
  always_comb begin
    unique case (fn)
      FN_EQC, FN_LDL, FN_GT, FN_TESTERR, FN_STOPERR: cost = COST_W'(2);
      FN_JMP:  cost = COST_W'(3);
      FN_CJMP: cost = taken ? COST_W'(4) : COST_W'(2);
      FN_STOP: cost = COST_W'(11);
      default: cost = COST_W'(1);
    endcase
  end
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
  import stk_pkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int BYTES_PER_WORD = 4,
  parameter int LEN_W          = 4,
  parameter int CLK_W          = 32,
  parameter logic [WORD_W-1:0] IPTR_RST = 32'h0000_1000,
  parameter logic [WORD_W-1:0] WPTR_RST = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [3:0]        ins_fn,
  input  logic [WORD_W-1:0] ins_oprnd,
  input  logic [LEN_W-1:0]  ins_len,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] reg_a,
  output logic [WORD_W-1:0] reg_b,
  output logic [WORD_W-1:0] reg_c,
  output logic [WORD_W-1:0] iptr,
  output logic [WORD_W-1:0] wptr,
  output logic              err_flag,
  output logic              halted,
  output logic [CLK_W-1:0]  cyc_count
);
  localparam int BSEL_W = $clog2(BYTES_PER_WORD);
  localparam logic [WORD_W-1:0] WSTEP = WORD_W'(BYTES_PER_WORD);

  stk_fn_e           fn;
  logic              fire;
  logic [WORD_W-1:0] alu_res, seq_iptr, nxt_iptr;
  logic              alu_ovf, taken;
  logic [COST_W-1:0] cost;

  logic [WORD_W-1:0] a_d, b_d, c_d;
  logic              err_d, halt_d;

  assign fn        = stk_fn_e'(ins_fn);
  assign ins_ready = rst_n && !halted;
  assign fire      = ins_valid && ins_ready;

  stk_alu #(.WORD_W(WORD_W)) u_alu (
    .fn(fn), .a(reg_a), .b(reg_b), .oprnd(ins_oprnd), .res(alu_res), .ovf(alu_ovf)
  );

  stk_branch #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_br (
    .fn(fn), .iptr(iptr), .len(ins_len), .oprnd(ins_oprnd), .a_zero(reg_a == '0),
    .seq_iptr(seq_iptr), .nxt_iptr(nxt_iptr), .taken(taken)
  );

  stk_cost u_cost (.fn(fn), .taken(taken), .cost(cost));

  // memory port: local access, store and the pointer save on stop
  always_comb begin
    mem_en    = fire && (fn == FN_LDL || fn == FN_STL || fn == FN_STOP);
    mem_we    = fire && (fn == FN_STL || fn == FN_STOP);
    mem_addr  = (fn == FN_STOP) ? (wptr - WSTEP) : (wptr + (ins_oprnd << BSEL_W));
    mem_wdata = (fn == FN_STOP) ? seq_iptr : reg_a;
  end

  always_comb begin
    a_d    = reg_a;
    b_d    = reg_b;
    c_d    = reg_c;
    err_d  = err_flag;
    halt_d = 1'b0;
    unique case (fn)
      FN_LDC, FN_LDL, FN_TESTERR: begin
        a_d = (fn == FN_LDC) ? ins_oprnd :
              (fn == FN_LDL) ? mem_rdata : {{(WORD_W-1){1'b0}}, err_flag};
        b_d = reg_a;
        c_d = reg_b;
        if (fn == FN_TESTERR) err_d = 1'b0;
      end
      FN_ADC: begin
        a_d = alu_res;
        if (alu_ovf) err_d = 1'b1;
      end
      FN_EQC: a_d = alu_res;
      FN_ADD, FN_SUB, FN_GT: begin
        a_d = alu_res;
        b_d = reg_c;
        if (alu_ovf) err_d = 1'b1;
      end
      FN_STL: begin
        a_d = reg_b;
        b_d = reg_c;
      end
      FN_CJMP: if (!taken) begin
        a_d = reg_b;
        b_d = reg_c;
      end
      FN_REV: begin
        a_d = reg_b;
        b_d = reg_a;
      end
      FN_SETERR:  err_d  = 1'b1;
      FN_STOPERR: halt_d = err_flag;
      FN_STOP:    halt_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iptr      <= IPTR_RST;
      wptr      <= WPTR_RST;
      halted    <= 1'b0;
      cyc_count <= '0;
      reg_a     <= '0;
      reg_b     <= '0;
      reg_c     <= '0;
    end else if (fire) begin
      iptr      <= nxt_iptr;
      halted    <= halt_d;
      cyc_count <= cyc_count + CLK_W'(cost);
      reg_a     <= a_d;
      reg_b     <= b_d;
      reg_c     <= c_d;
    end
  end

  // the error flag carries no reset value by intent
  always_ff @(posedge clk) begin
    if (fire) err_flag <= err_d;
  end
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk #(
  parameter int WORD_W = 32,
  parameter int CLK_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [3:0]        ins_fn,
  input logic [WORD_W-1:0] ins_oprnd,
  input logic [WORD_W-1:0] reg_a,
  input logic [WORD_W-1:0] reg_b,
  input logic [WORD_W-1:0] reg_c,
  input logic [WORD_W-1:0] iptr,
  input logic              halted,
  input logic [CLK_W-1:0]  cyc_count
);
  logic fire;
  assign fire = ins_valid && ins_ready;

  AST_HALT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !ins_ready); // R11

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(reg_a) && $stable(iptr) && $stable(cyc_count)); // R11

  AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_fn == 4'd0) |=> (reg_a == $past(ins_oprnd)) && (reg_b == $past(reg_a))
                                 && (reg_c == $past(reg_b))); // R2

  AST_LDC_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_fn == 4'd0) |=> cyc_count == $past(cyc_count) + 1'b1); // R12

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_fn == 4'd14) |=> halted); // R10

  AST_CJ_FALLTHRU_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_fn == 4'd6 && reg_a != '0) |=> reg_a == $past(reg_b)); // R7

  AST_REV_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_fn == 4'd10) |=> (reg_a == $past(reg_b)) && (reg_b == $past(reg_a))); // R8
endmodule

bind stk_exec_unit stk_exec_chk #(.WORD_W(WORD_W), .CLK_W(CLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_fn(ins_fn), .ins_oprnd(ins_oprnd), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
  .iptr(iptr), .halted(halted), .cyc_count(cyc_count)
);

// File: tb/tb_stk_exec_unit.sv
module tb_stk_exec_unit;
  localparam int W = 32;
  localparam logic [31:0] IP0 = 32'h0000_1000;
  localparam logic [31:0] WP0 = 32'h0000_0100;

  logic clk = 0, rst_n = 0, ins_valid = 0;
  logic [3:0] ins_fn = 0;
  logic [W-1:0] ins_oprnd = 0;
  logic [3:0] ins_len = 1;
  logic ins_ready, mem_en, mem_we, err_flag, halted;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata, reg_a, reg_b, reg_c, iptr, wptr;
  logic [31:0] cyc_count;
  logic [31:0] mem [0:255];

  int n_chk = 0, n_fail = 0;
  logic [31:0] ea, eb, ec, ei, ecy;
  logic ee;

  always #4 clk = ~clk;

  stk_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_fn(ins_fn), .ins_oprnd(ins_oprnd), .ins_len(ins_len),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .iptr(iptr),
    .wptr(wptr), .err_flag(err_flag), .halted(halted), .cyc_count(cyc_count)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_en && mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int cost_of(input int f, input bit tk);
    case (f)
      2, 3, 9, 12, 13: return 2;
      5: return 3;
      6: return tk ? 4 : 2;
      14: return 11;
      default: return 1;
    endcase
  endfunction

  function automatic bit add_ovf(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] s = x + y;
    return (x[31] == y[31]) && (s[31] != x[31]);
  endfunction

  // reference model update for one retired instruction
  task automatic model(input int f, input logic [31:0] op, input logic [3:0] ln);
    logic [31:0] nx = ei + 32'(ln);
    bit tk = 0;
    case (f)
      0:  begin ec = eb; eb = ea; ea = op; end
      1:  begin if (add_ovf(ea, op)) ee = 1; ea = ea + op; end
      2:  ea = (ea == op) ? 1 : 0;
      3:  begin ec = eb; eb = ea; ea = mem[8'((WP0 + (op << 2)) >> 2)]; end
      4:  begin ea = eb; eb = ec; end
      5:  begin tk = 1; nx = nx + op; end
      6:  if (ea == 0) begin tk = 1; nx = nx + op; end else begin ea = eb; eb = ec; end
      7:  begin if (add_ovf(eb, ea)) ee = 1; ea = eb + ea; eb = ec; end
      8:  begin if ((eb[31] != ea[31]) && ((eb - ea) >> 31) != {31'd0, eb[31]}) ee = 1;
                ea = eb - ea; eb = ec; end
      9:  begin ea = ($signed(eb) > $signed(ea)) ? 1 : 0; eb = ec; end
      10: begin logic [31:0] t = ea; ea = eb; eb = t; end
      11: ee = 1;
      12: begin ec = eb; eb = ea; ea = {31'd0, ee}; ee = 0; end
      default: ;
    endcase
    ei = nx;
    ecy = ecy + 32'(cost_of(f, tk));
  endtask

  task automatic exec(input int f, input logic [31:0] op, input logic [3:0] ln, input string req);
    logic [31:0] sa = ea;
    @(negedge clk);
    ins_fn = 4'(f); ins_oprnd = op; ins_len = ln; ins_valid = 1;
    model(f, op, ln);
    @(negedge clk);
    ins_valid = 0;
    chk(reg_a == ea, req, reg_a, ea);
    chk(reg_b == eb && reg_c == ec, req, reg_b, eb);
    chk(iptr == ei, {req, "/R7"}, iptr, ei);
    chk(err_flag == ee, req, {31'd0, err_flag}, {31'd0, ee});
    chk(cyc_count == ecy, {req, "/R12"}, cyc_count, ecy);
    if (f == 4) chk(mem[8'((WP0 + (op << 2)) >> 2)] == sa, "R6 store", mem[8'((WP0 + (op << 2)) >> 2)], sa);
  endtask

  task automatic do_reset;
    rst_n = 0; ins_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ea = 0; eb = 0; ec = 0; ei = IP0; ecy = 0;
    @(negedge clk);
    chk(iptr == IP0 && wptr == WP0, "R1 pointers", iptr, IP0);
    chk(cyc_count == 0, "R1 counter", cyc_count, 0);
    chk(!halted && ins_ready, "R1 running", {30'd0, halted, ins_ready}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    do_reset();
    ee = 1;
    exec(11, 0, 1, "R9 set");
    exec(12, 0, 1, "R9 test set");
    exec(12, 0, 1, "R9 test clear");
    // directed corners
    exec(0, 32'h7fff_ffff, 1, "R2 ldc");
    exec(0, 32'h0000_0001, 2, "R2 ldc");
    exec(7, 0, 1, "R4 add overflow");
    exec(12, 0, 1, "R9 after ovf");
    exec(0, 32'h8000_0000, 1, "R2 ldc");
    exec(0, 32'h0000_0001, 1, "R2 ldc");
    exec(8, 0, 1, "R4 sub overflow");
    exec(12, 0, 1, "R9 after sub ovf");
    exec(0, 32'hffff_fffe, 1, "R2 ldc");
    exec(0, 32'h0000_0003, 1, "R2 ldc");
    exec(9, 0, 1, "R5 gt signed");
    exec(2, 0, 1, "R5 eqc zero");
    exec(6, 32'h10, 2, "R7 cj fallthrough");
    exec(0, 0, 1, "R2 ldc");
    exec(6, 32'hffff_fff0, 3, "R7 cj taken");
    exec(5, 32'h20, 1, "R7 jump");
    exec(10, 0, 1, "R8 rev");
    exec(4, 5, 1, "R6 stl");
    exec(3, 5, 1, "R6 ldl");
    exec(1, 32'h7fff_ffff, 1, "R4 adc");
    exec(15, 0, 2, "R7 nop");
    // constrained random
    for (int k = 0; k < 400; k++) begin
      int f = $urandom_range(0, 12);
      logic [31:0] op = $urandom;
      if (f == 3 || f == 4) op = $urandom_range(0, 31);
      if (f == 5 || f == 6) op = {{24{op[7]}}, op[7:0]};
      if (f == 2 && op[0]) op = ea;
      exec(f, op, 4'($urandom_range(1, 4)), "R3 random");
    end
    // stop-on-error with flag clear: keeps running
    exec(12, 0, 1, "R9 clear");
    exec(13, 0, 1, "R10 stoperr clear");
    chk(!halted, "R10 no halt", {31'd0, halted}, 0);
    // overflow then stop-on-error back to back
    exec(0, 32'h7fff_ffff, 1, "R2 ldc");
    exec(0, 32'h7fff_ffff, 1, "R2 ldc");
    @(negedge clk);
    ins_fn = 4'd7; ins_valid = 1; ins_len = 1; model(7, 0, 1);
    @(negedge clk);
    ins_fn = 4'd13; model(13, 0, 1);
    @(negedge clk);
    chk(halted && !ins_ready, "R10 stoperr halts", {30'd0, halted, ins_ready}, 32'd2);
    ins_fn = 4'd0; ins_oprnd = 32'h55;
    repeat (2) @(negedge clk);
    chk(reg_a == ea && iptr == ei && cyc_count == ecy, "R11 frozen", reg_a, ea);
    ins_valid = 0;
    // stop saves pointer
    do_reset();
    exec(0, 32'h1, 1, "R2 ldc");
    @(negedge clk);
    ins_fn = 4'd14; ins_len = 3; ins_valid = 1; model(14, 0, 3);
    @(negedge clk);
    ins_valid = 0;
    chk(halted, "R10 stop halts", {31'd0, halted}, 1);
    chk(mem[8'((WP0 - 4) >> 2)] == ei, "R10 saved iptr", mem[8'((WP0 - 4) >> 2)], ei);
    chk(cyc_count == ecy, "R12 stop cost", cyc_count, ecy);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule